// File: doc/BRIEF.md
# LZW Block Decompression Engine

This engine rebuilds a byte stream from LZW codewords. Codewords arrive one at a time on a valid/ready input together with a flag that marks the first codeword of a compressed block. Every block starts from a fresh table holding only the 256 single-byte phrases. Each codeword is turned back into the phrase it names, and the bytes leave on a valid/ready output in their original order. While it does this, the engine grows its table the same way the compressor grew its own.

Each table entry stores a link to a prefix entry and one trailing byte. To expand a phrase, the engine follows these links from the last byte back to the first and pushes each byte onto a stack. It then pops the stack, so the bytes come out first to last. The codeword input is held off while a phrase is being expanded and sent.

In fixed mode every codeword uses the full configured width. In dynamic mode the width starts at 9 bits and gains one bit each time the next free table index no longer fits. The engine reports that width so an upstream bit unpacker can slice the next codeword correctly.

Top module: `lzw_block_decoder`

## Requirements
- R1: For each accepted codeword the engine emits every byte of the phrase that codeword indexes, first byte first, and the bytes across codewords form the original block.
- R2: After each codeword other than the first of a block, the next free table entry is set to the previous phrase followed by the first byte of the current phrase. The free index then advances by one.
- R3: A codeword equal to the next free index (one not yet written) decodes to the previous phrase followed by that phrase's own first byte.
- R4: A codeword accepted with `inStart` high empties the table back to the 256 single-byte phrases (codes 0 to 255). That first codeword adds no entry. Phrases learned in an earlier block never affect a later one.
- R5: When every index up to 2^CODE_W - 1 is in use, no further entries are written and decoding of the block continues correctly.
- R6: With DYNAMIC=1, `cwWidth` shows the smallest width of at least 9 bits that can hold the next free index, capped at CODE_W. It never shrinks within a block. With DYNAMIC=0 it always equals CODE_W.
- R7: Codeword bits at or above the current width are ignored. With DYNAMIC=1, a codeword flagged by `inStart` is read with 9 bits.
- R8: `inReady` drops after a codeword is accepted and stays low until the last byte of its phrase has been taken. While `outValid` is high and `outReady` is low, `outValid` and `outByte` do not change.
- R9: After reset, `inReady` is 1, `outValid` is 0 and `cwWidth` is 9 when DYNAMIC=1 (CODE_W when DYNAMIC=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Codeword present |
| inReady | output | 1 | Engine can take a codeword |
| inCode | input | CODE_W | Codeword; bits above the current width are ignored |
| inStart | input | 1 | Codeword is the first of a new block |
| outValid | output | 1 | Output byte present |
| outReady | input | 1 | Consumer takes the byte |
| outByte | output | 8 | Decoded byte |
| cwWidth | output | 4 | Width in bits of the next continuing codeword |

## Verification
The bench builds two instances. The first uses dynamic width with CODE_W=10, so it has a 768-entry table: long random blocks fill that table, which exercises the 9-to-10-bit width step and the point where entries stop being written. The second uses fixed width with CODE_W=9, where a full table comes after only 256 entries. That makes saturation with a small alphabet cheap to reach and checks the fixed-width report. A reference compressor in the bench produces the codewords, including runs that force the not-yet-written-index case. Random bits above the active width are added to each codeword to show they are ignored.

// File: rtl/lzwd_pkg.sv
package lzwd_pkg;
  typedef enum logic [1:0] {
    PH_TAKE,
    PH_WALK,
    PH_SEND
  } phase_t;

  typedef struct packed {
    logic load;
    logic walk;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/lzwd_ctrl.sv
module lzwd_ctrl
  import lzwd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    walkLeaf,
  input  logic    lastByte,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strobes
);
  phase_t phase, phaseNext;

  always_comb begin
    inReady      = (phase == PH_TAKE);
    outValid     = (phase == PH_SEND);
    strobes.load = inReady && inValid;
    strobes.walk = (phase == PH_WALK);
    strobes.pop  = outValid && outReady;
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_TAKE: if (strobes.load) phaseNext = PH_WALK;
      PH_WALK: if (walkLeaf) phaseNext = PH_SEND;
      PH_SEND: if (strobes.pop && lastByte) phaseNext = PH_TAKE;
      default: phaseNext = PH_TAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_TAKE;
    else       phase <= phaseNext;
  end

  // R8: input stays closed in the cycle after a codeword is taken
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
endmodule

// File: rtl/lzwd_path.sv
module lzwd_path
  import lzwd_pkg::*;
#(
  parameter int CW_MAX  = 10,
  parameter bit DYNAMIC = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [CW_MAX-1:0] inCode,
  input  logic              inStart,
  output logic              walkLeaf,
  output logic              lastByte,
  output logic [7:0]        outByte,
  output logic [3:0]        cwWidth
);
  localparam int ENTRIES = (1 << CW_MAX) - 256;
  localparam int DEPTH   = ENTRIES + 1;
  localparam int SP_W    = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int NF_W    = CW_MAX + 1;
  localparam logic [NF_W-1:0] NF_BASE  = NF_W'(256);
  localparam logic [NF_W-1:0] NF_LIMIT = NF_W'(1 << CW_MAX);

  logic [CW_MAX-1:0] tPrefix [ENTRIES];
  logic [7:0]        tLast   [ENTRIES];
  logic [7:0]        stack   [DEPTH];

  logic [SP_W-1:0]   sp;
  logic [NF_W-1:0]   nextFree;
  logic              havePrev;
  logic [CW_MAX-1:0] prevCode, curCode, walkIdx;
  logic [7:0]        prevFirst;

  logic [3:0]        curWidth, takeWidth;
  logic [CW_MAX-1:0] codeMask, maskedCode;
  logic [NF_W-1:0]   effNext;
  logic              effHave, isRepeat, tableAdd;
  logic [IDX_W-1:0]  tIdx, wIdx;

  generate
    if (DYNAMIC) begin : g_dynWidth
      always_comb begin
        curWidth = 4'd9;
        for (int w = 9; w < CW_MAX; w++)
          if (nextFree >= NF_W'(1 << w)) curWidth = 4'(w + 1);
      end
    end else begin : g_fixWidth
      assign curWidth = 4'(CW_MAX);
    end
  endgenerate

  always_comb begin
    takeWidth = (DYNAMIC && inStart) ? 4'd9 : curWidth;
    for (int b = 0; b < CW_MAX; b++) codeMask[b] = (b < int'(takeWidth));
    maskedCode = inCode & codeMask;
    effNext    = inStart ? NF_BASE : nextFree;
    effHave    = inStart ? 1'b0 : havePrev;
    isRepeat   = effHave && ({1'b0, maskedCode} == effNext);
    walkLeaf   = (walkIdx[CW_MAX-1:8] == '0);
    tIdx       = IDX_W'(walkIdx - CW_MAX'(256));
    wIdx       = IDX_W'(nextFree - NF_BASE);
    tableAdd   = havePrev && (nextFree != NF_LIMIT);
    lastByte   = (sp == SP_W'(1));
    outByte    = stack[sp - SP_W'(1)];
    cwWidth    = curWidth;
  end

  // storage arrays carry no reset
  always_ff @(posedge clk) begin
    if (strobes.load && isRepeat) stack[0] <= prevFirst;
    if (strobes.walk) begin
      stack[sp] <= walkLeaf ? walkIdx[7:0] : tLast[tIdx];
      if (walkLeaf && tableAdd) begin
        tPrefix[wIdx] <= prevCode;
        tLast[wIdx]   <= walkIdx[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp        <= '0;
      nextFree  <= NF_BASE;
      havePrev  <= 1'b0;
      prevCode  <= '0;
      curCode   <= '0;
      walkIdx   <= '0;
      prevFirst <= '0;
    end else begin
      if (strobes.load) begin
        curCode <= maskedCode;
        if (inStart) begin
          nextFree <= NF_BASE;
          havePrev <= 1'b0;
        end
        if (isRepeat) begin
          sp      <= SP_W'(1);
          walkIdx <= prevCode;
        end else begin
          sp      <= '0;
          walkIdx <= maskedCode;
        end
      end
      if (strobes.walk) begin
        sp <= sp + SP_W'(1);
        if (walkLeaf) begin
          prevFirst <= walkIdx[7:0];
          prevCode  <= curCode;
          havePrev  <= 1'b1;
          if (tableAdd) nextFree <= nextFree + NF_W'(1);
        end else begin
          walkIdx <= tPrefix[tIdx];
        end
      end
      if (strobes.pop) sp <= sp - SP_W'(1);
    end
  end

  assert_stack_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(DEPTH));

  assert_block_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && inStart) |=> (nextFree == NF_BASE) && !havePrev);

  assert_first_no_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.walk && !havePrev) |=> nextFree == $past(nextFree));

  assert_table_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (nextFree == NF_LIMIT && !(strobes.load && inStart)) |=> nextFree == NF_LIMIT);

  assert_width_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cwWidth >= 4'd9) && (cwWidth <= 4'(CW_MAX)));

  assert_width_grow_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && inStart) |=> cwWidth >= $past(cwWidth));
endmodule

// File: rtl/lzw_block_decoder.sv
module lzw_block_decoder
  import lzwd_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter bit DYNAMIC = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] inCode,
  input  logic              inStart,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outByte,
  output logic [3:0]        cwWidth
);
  strobe_t strobes;
  logic    walkLeaf, lastByte;

  lzwd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .walkLeaf (walkLeaf),
    .lastByte (lastByte),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  lzwd_path #(.CW_MAX(CODE_W), .DYNAMIC(DYNAMIC)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inCode   (inCode),
    .inStart  (inStart),
    .walkLeaf (walkLeaf),
    .lastByte (lastByte),
    .outByte  (outByte),
    .cwWidth  (cwWidth)
  );

  // R8: a byte waiting on backpressure is held unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outByte));
endmodule

// File: tb/tb_lzw_block_decoder.sv
module tb_lzw_block_decoder;
  localparam int DYN_W = 10;
  localparam int FIX_W = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic             inValid = 1'b0, inStart = 1'b0, outReady = 1'b0;
  logic [DYN_W-1:0] inCode = '0;
  logic             sel = 1'b0; // 0: dynamic dut, 1: fixed dutFix

  logic rdyD, vldD, rdyF, vldF;
  logic [7:0] byteD, byteF;
  logic [3:0] widD, widF;

  lzw_block_decoder #(.CODE_W(DYN_W), .DYNAMIC(1'b1)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid && !sel), .inReady(rdyD),
    .inCode(inCode), .inStart(inStart), .outValid(vldD),
    .outReady(outReady && !sel), .outByte(byteD), .cwWidth(widD));

  lzw_block_decoder #(.CODE_W(FIX_W), .DYNAMIC(1'b0)) dutFix (
    .clk(clk), .rstN(rstN), .inValid(inValid && sel), .inReady(rdyF),
    .inCode(inCode[FIX_W-1:0]), .inStart(inStart), .outValid(vldF),
    .outReady(outReady && sel), .outByte(byteF), .cwWidth(widF));

  wire       rdyS  = sel ? rdyF : rdyD;
  wire       vldS  = sel ? vldF : vldD;
  wire [7:0] byteS = sel ? byteF : byteD;

  int compared = 0, mismatched = 0;
  string curTag = "R1";
  logic [7:0] blk[$];
  logic [7:0] expQ[$];
  int codes[$];
  int widths[$];

  function automatic int widthFor(int nf, int cw);
    int w = 9;
    while (w < cw && nf >= (1 << w)) w++;
    return w;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference compressor over blk
  task automatic compress(int cw, bit dyn);
    int dict[int];
    int nf, cur, j, w, nfD;
    nf = 256; cur = -1;
    codes.delete(); widths.delete();
    for (int i = 0; i <= blk.size(); i++) begin
      if (i < blk.size() && cur < 0) cur = int'(blk[i]);
      else if (i < blk.size() && dict.exists(cur * 256 + int'(blk[i])))
        cur = dict[cur * 256 + int'(blk[i])];
      else begin
        j = codes.size();
        if (!dyn) w = cw;
        else if (j == 0) w = 9;
        else begin
          nfD = 256 + (((j - 1) < ((1 << cw) - 256)) ? (j - 1) : ((1 << cw) - 256));
          w = widthFor(nfD, cw);
        end
        codes.push_back(cur);
        widths.push_back(w);
        if (i < blk.size()) begin
          if (nf < (1 << cw)) begin
            dict[cur * 256 + int'(blk[i])] = nf;
            nf++;
          end
          cur = int'(blk[i]);
        end
      end
    end
  endtask

  task automatic runBlock(bit useFix, string tag);
    int cw;
    logic [DYN_W-1:0] junk;
    cw = useFix ? FIX_W : DYN_W;
    sel = useFix;
    curTag = tag;
    compress(cw, !useFix);
    foreach (blk[i]) expQ.push_back(blk[i]);
    for (int j = 0; j < codes.size(); j++) begin
      @(negedge clk);
      while (!rdyS) @(negedge clk);
      if (!useFix && j > 0) check("R6", int'(widD), widths[j], "codeword width");
      junk = DYN_W'($urandom);
      inCode  = (DYN_W'(codes[j]) | (junk << widths[j])); // R7 junk above width
      inStart = (j == 0);
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      inStart = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // output consumer with random backpressure
  initial begin
    bit pend = 1'b0;
    logic [7:0] held = '0;
    bit r;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (pend) begin
        check("R8", int'(vldS), 1, "valid held under backpressure");
        check("R8", int'(byteS), int'(held), "byte held under backpressure");
      end
      r = ($urandom % 4) != 0;
      outReady = r;
      pend = 1'b0;
      if (vldS) begin
        check("R8", int'(rdyS), 0, "input closed while sending");
        if (r) begin
          if (expQ.size() == 0) check(curTag, int'(byteS), -1, "unexpected byte");
          else check(curTag, int'(byteS), int'(expQ.pop_front()), "decoded byte");
        end else begin
          pend = 1'b1;
          held = byteS;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    string s;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R9", int'(rdyD), 1, "inReady after reset");
    check("R9", int'(vldD), 0, "outValid after reset");
    check("R9", int'(widD), 9, "dynamic width after reset");
    check("R9", int'(widF), FIX_W, "fixed width after reset");
    rstN = 1'b1;
    @(negedge clk);

    // R2: repeated substrings build and reuse entries
    s = "TOBEORNOTTOBEORTOBEORNOTTOBE";
    blk.delete();
    for (int i = 0; i < s.len(); i++) blk.push_back(s[i]);
    runBlock(1'b0, "R2");

    // R3: a single-byte run hits the not-yet-written index
    blk.delete();
    repeat (40) blk.push_back(8'h61);
    runBlock(1'b0, "R3");

    // R5: random data fills the 10-bit table
    blk.delete();
    repeat (2600) blk.push_back(8'($urandom));
    runBlock(1'b0, "R5");

    // R4: new block right after a full table
    blk.delete();
    s = "abababababcabcabc";
    for (int i = 0; i < s.len(); i++) blk.push_back(s[i]);
    runBlock(1'b0, "R4");

    // R6: fixed width stays at CODE_W
    check("R6", int'(widF), FIX_W, "fixed width");

    // R5: small alphabet fills the 9-bit table
    blk.delete();
    repeat (2000) blk.push_back(8'(8'h30 + ($urandom % 6)));
    runBlock(1'b1, "R5");

    // R3: run on the fixed engine
    blk.delete();
    repeat (25) blk.push_back(8'h00);
    runBlock(1'b1, "R3");

    // R1/R7: random short blocks, both engines, one-byte blocks included
    for (int k = 0; k < 10; k++) begin
      int len, alpha;
      len = (k == 0) ? 1 : 1 + ($urandom % 80);
      alpha = 2 + ($urandom % 200);
      blk.delete();
      repeat (len) blk.push_back(8'($urandom % alpha));
      runBlock(k[0], (k % 3 == 0) ? "R7" : "R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule